// File: doc/BRIEF.md
# Interrupt mask and serial-output register

This block holds the state written by a "set interrupt masks" operation in a small 8-bit processor. When the write strobe is high, an 8-bit accumulator word is applied field by field, and each field takes effect only if its own enable bit in the same word is set. One field enables a load of three interrupt mask bits. Another bit clears the capture latch of the edge-triggered interrupt. A third enables a load of a one-bit serial output latch.

There are three interrupt lines. A (lowest priority) and B are level inputs. C (highest priority) is edge-triggered. The C input is asynchronous. It passes through a two-flop synchronizer, and every rising edge sets a capture latch, even while C is masked. Each line has a pending output, which is the request gated by its mask. The processor's acknowledge of C clears the latch, but only when C is unmasked.

The decoder, vectoring, the global interrupt enable and the read-back path sit outside this block. The mask bits, the C latch and the serial output latch are brought out as read-only ports.

Top module: `irq_mask_unit`

## Requirements
- R1: A write with bit 3 of `wr_data` set loads bits 2..0 into the masks. Bit 0 masks A, bit 1 masks B and bit 2 masks C, and a mask value of 1 disables its line. The new masks appear after the next rising clock edge.
- R2: A write with bit 3 clear, or no write at all, leaves `mask_o` unchanged.
- R3: A rising edge on `irq_c_pin` sets `c_latch_o` whatever the C mask holds. The pin is driven high between clock edges, and the latch reads 1 after the third rising edge that follows (two synchronizer flops plus the latch).
- R4: A write with bit 4 set clears `c_latch_o` at the next edge.
- R5: `irq_c_ack` clears `c_latch_o` at the next edge only while mask bit 2 is 0. While mask bit 2 is 1, the acknowledge has no effect.
- R6: If a rising edge is detected in the same cycle as a clear (from R4 or R5), the edge wins and `c_latch_o` is 1 after that edge.
- R7: A write with bit 6 set loads bit 7 into `ser_out_o`. A write with bit 6 clear leaves `ser_out_o` unchanged.
- R8: Bit 5 of `wr_data` has no effect. A write of 0x20 changes no output.
- R9: `pend_a` = `irq_a_lvl` AND NOT mask bit 0, `pend_b` = `irq_b_lvl` AND NOT mask bit 1, and `pend_c` = `c_latch_o` AND NOT mask bit 2. All three are combinational from the current state.
- R10: A synchronous active-low reset sets `mask_o` to 3'b111 and clears `ser_out_o`, `c_latch_o` and the synchronizer. A pin that is high when reset releases is therefore seen as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the accumulator word |
| wr_data | input | 8 | Accumulator word |
| irq_a_lvl | input | 1 | Level request, line A |
| irq_b_lvl | input | 1 | Level request, line B |
| irq_c_pin | input | 1 | Asynchronous edge request, line C |
| irq_c_ack | input | 1 | Acknowledge of line C |
| pend_a | output | 1 | Masked pending request A |
| pend_b | output | 1 | Masked pending request B |
| pend_c | output | 1 | Masked pending request C |
| mask_o | output | 3 | Current masks {C,B,A} |
| c_latch_o | output | 1 | Edge capture latch of line C |
| ser_out_o | output | 1 | Serial output data latch |

## Verification
The assertions assume that `wr_en`, `wr_data` and `irq_c_ack` are synchronous to `clk` and hold steady around each rising edge. Only `irq_c_pin` may change at any time, and the synchronizer absorbs it. The bench changes every input, the C pin included, on the falling edge. This keeps the pipeline timing deterministic, so a reference model stepped once per rising edge can predict every output. Random cycles set the write bits independently, so enable and data combinations occur freely. Directed sequences line up a detected edge with a clear in the same cycle, and an acknowledge with a set C mask.

// File: rtl/irqm_pkg.sv
// Package irqm_pkg: bit positions within the write word and widths shared by
// the interrupt mask unit. The positions are fixed by the software contract
// of the write operation.
package irqm_pkg;
    localparam int WORD_W     = 8;  // accumulator word width
    localparam int N_IRQ      = 3;  // number of maskable lines
    localparam int MASK_LSB   = 0;  // masks occupy MASK_LSB+N_IRQ-1 .. MASK_LSB
    localparam int MASK_EN_B  = 3;  // mask load enable
    localparam int CLR_C_B    = 4;  // clear edge latch of line C
    localparam int SER_EN_B   = 6;  // serial latch load enable
    localparam int SER_DAT_B  = 7;  // serial latch data
    localparam logic [N_IRQ-1:0] MASK_RST = '1;  // all lines masked after reset
endpackage

// File: rtl/irqm_sync.sv
// Module irqm_sync: multi-stage synchronizer for one asynchronous input.
// Assumes STAGES >= 2. All stages are cleared by the synchronous reset.
module irqm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] stg_q;

    // Shift the asynchronous input through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[STAGES-2:0], d_async};
    end

    assign d_sync = stg_q[STAGES-1];
endmodule

// File: rtl/irqm_edge_latch.sv
// Module irqm_edge_latch: detects a rising edge on a synchronized input and
// holds it in a capture latch until cleared. A detected edge has priority
// over a clear in the same cycle. Assumes smp_i is already synchronous.
module irqm_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_i,
    input  logic clr_i,
    output logic rise_o,
    output logic latch_o
);
    logic prev_q;

    // Remember the previous sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= smp_i;
    end

    assign rise_o = smp_i & ~prev_q;

    // Set on an edge, otherwise clear on request, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      latch_o <= 1'b0;
        else if (rise_o) latch_o <= 1'b1;
        else if (clr_i)  latch_o <= 1'b0;
    end
endmodule

// File: rtl/irqm_ctrl_regs.sv
// Module irqm_ctrl_regs: mask and serial-output registers loaded from the
// write word, each field gated by its own enable bit. The undefined bit is
// not decoded. Assumes wr_en and wr_data are synchronous to clk.
module irqm_ctrl_regs
    import irqm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [N_IRQ-1:0]  mask_q,
    output logic              ser_q
);
    logic mask_ld;
    logic ser_ld;

    assign mask_ld = wr_en & wr_data[MASK_EN_B];
    assign ser_ld  = wr_en & wr_data[SER_EN_B];

    // Mask register: load on enabled write, all set on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= MASK_RST;
        else if (mask_ld) mask_q <= wr_data[MASK_LSB +: N_IRQ];
    end

    // Serial output latch: load data bit on enabled write, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      ser_q <= 1'b0;
        else if (ser_ld) ser_q <= wr_data[SER_DAT_B];
    end
endmodule

// File: rtl/irqm_gate.sv
// Module irqm_gate: combines requests with their masks. A mask bit of 1 blocks
// its request. Purely combinational.
module irqm_gate #(
    parameter int N = 3
) (
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] pend_o
);
    // One gate per line.
    for (genvar g = 0; g < N; g++) begin : g_line
        assign pend_o[g] = req_i[g] & ~mask_i[g];
    end
endmodule

// File: rtl/irq_mask_unit.sv
// Module irq_mask_unit: interrupt mask and serial-output register. Holds three
// interrupt masks, an edge capture latch for line C and a serial output latch,
// all updated by an accumulator write. Drives masked pending outputs. Assumes
// all inputs except irq_c_pin are synchronous to clk.
module irq_mask_unit
    import irqm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              irq_a_lvl,
    input  logic              irq_b_lvl,
    input  logic              irq_c_pin,
    input  logic              irq_c_ack,
    output logic              pend_a,
    output logic              pend_b,
    output logic              pend_c,
    output logic [N_IRQ-1:0]  mask_o,
    output logic              c_latch_o,
    output logic              ser_out_o
);
    logic             c_smp;
    logic             rise_w;
    logic             c_clr;
    logic [N_IRQ-1:0] req_w;
    logic [N_IRQ-1:0] pend_w;

    irqm_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(irq_c_pin),
        .d_sync (c_smp)
    );

    // Clear from an enabled write, or from an acknowledge while line C is unmasked.
    assign c_clr = (wr_en & wr_data[CLR_C_B]) | (irq_c_ack & ~mask_o[N_IRQ-1]);

    irqm_edge_latch edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_i  (c_smp),
        .clr_i  (c_clr),
        .rise_o (rise_w),
        .latch_o(c_latch_o)
    );

    irqm_ctrl_regs regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .mask_q (mask_o),
        .ser_q  (ser_out_o)
    );

    assign req_w = {c_latch_o, irq_b_lvl, irq_a_lvl};

    irqm_gate #(.N(N_IRQ)) gate_i (
        .req_i (req_w),
        .mask_i(mask_o),
        .pend_o(pend_w)
    );

    assign pend_a = pend_w[0];
    assign pend_b = pend_w[1];
    assign pend_c = pend_w[2];
endmodule

// File: rtl/irqm_chk.sv
// Module irqm_chk: property checker for irq_mask_unit, attached by bind.
// Assumes the synchronous inputs are stable around each rising clock edge.
module irqm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       irq_c_ack,
    input logic       rise,
    input logic [2:0] mask_o,
    input logic       c_latch_o,
    input logic       ser_out_o,
    input logic       pend_c
);
    // R1
    load_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[3]) |=> (mask_o == $past(wr_data[2:0])));

    // R2
    keep_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_data[3]) |=> $stable(mask_o));

    // R4
    wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[4] && !rise) |=> !c_latch_o);

    // R5
    masked_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_latch_o && mask_o[2] && !(wr_en && wr_data[4])) |=> c_latch_o);

    // R6
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> c_latch_o);

    // R7
    load_ser_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[6]) |=> (ser_out_o == $past(wr_data[7])));

    // R7
    keep_ser_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_data[6]) |=> $stable(ser_out_o));

    // R9
    pend_c_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_c |-> (c_latch_o && !mask_o[2]));

    // R10
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (mask_o == 3'b111 && !ser_out_o && !c_latch_o));
endmodule

bind irq_mask_unit irqm_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .irq_c_ack(irq_c_ack),
    .rise     (rise_w),
    .mask_o   (mask_o),
    .c_latch_o(c_latch_o),
    .ser_out_o(ser_out_o),
    .pend_c   (pend_c)
);

// File: tb/irq_mask_unit_tb_top.sv
// Bench for irq_mask_unit: directed corner cases plus seeded random cycles,
// compared each cycle against a reference model stepped per rising edge.
module irq_mask_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       irq_a_lvl = 1'b0;
    logic       irq_b_lvl = 1'b0;
    logic       irq_c_pin = 1'b0;
    logic       irq_c_ack = 1'b0;
    logic       pend_a, pend_b, pend_c;
    logic [2:0] mask_o;
    logic       c_latch_o, ser_out_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference model state
    logic [2:0] m_mask = 3'b111;
    logic       m_ser = 1'b0, m_latch = 1'b0;
    logic       m_s1 = 1'b0, m_s2 = 1'b0, m_prev = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    irq_mask_unit dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .irq_a_lvl(irq_a_lvl), .irq_b_lvl(irq_b_lvl), .irq_c_pin(irq_c_pin),
        .irq_c_ack(irq_c_ack), .pend_a(pend_a), .pend_b(pend_b), .pend_c(pend_c),
        .mask_o(mask_o), .c_latch_o(c_latch_o), .ser_out_o(ser_out_o)
    );

    // Expected output vector {mask, latch, ser, pend_a, pend_b, pend_c}
    function automatic logic [7:0] exp_vec();
        return {m_mask, m_latch, m_ser, irq_a_lvl & ~m_mask[0],
                irq_b_lvl & ~m_mask[1], m_latch & ~m_mask[2]};
    endfunction

    // Advance the model by one rising edge using the current inputs
    function automatic void model_step();
        logic rise, clr;
        if (!rst_n) begin
            m_mask = 3'b111; m_ser = 1'b0; m_latch = 1'b0;
            m_s1 = 1'b0; m_s2 = 1'b0; m_prev = 1'b0;
        end else begin
            rise = m_s2 & ~m_prev;
            clr  = (wr_en & wr_data[4]) | (irq_c_ack & ~m_mask[2]);
            m_latch = rise | (m_latch & ~clr);
            m_prev = m_s2;
            m_s2 = m_s1;
            m_s1 = irq_c_pin;
            if (wr_en && wr_data[3]) m_mask = wr_data[2:0];
            if (wr_en && wr_data[6]) m_ser = wr_data[7];
        end
    endfunction

    task automatic check(input string tag);
        logic [7:0] act, exp;
        act = {mask_o, c_latch_o, ser_out_o, pend_a, pend_b, pend_c};
        exp = exp_vec();
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // One cycle: drive inputs after a falling edge, step at the rising edge, check at the next falling edge
    task automatic cyc(input logic rn, input logic we, input logic [7:0] wd,
                       input logic a, input logic b, input logic pin,
                       input logic ack, input string tag);
        rst_n = rn; wr_en = we; wr_data = wd;
        irq_a_lvl = a; irq_b_lvl = b; irq_c_pin = pin; irq_c_ack = ack;
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        void'($urandom(32'h1F2E3D4C));
        @(negedge clk);
        cyc(0, 0, 8'h00, 0, 0, 0, 0, "R10");
        cyc(0, 0, 8'h00, 1, 1, 0, 0, "R10");
        // R10: all masked after reset, so level requests stay blocked
        cyc(1, 0, 8'h00, 1, 1, 0, 0, "R10");
        // R1: mask load 0b101
        cyc(1, 1, 8'h0D, 1, 1, 0, 0, "R1");
        // R2: no enable, masks unchanged
        cyc(1, 1, 8'h02, 1, 1, 0, 0, "R2");
        // R8: undefined bit alone changes nothing
        cyc(1, 1, 8'h20, 1, 1, 0, 0, "R8");
        // R1/R9: mask only C
        cyc(1, 1, 8'h0C, 1, 1, 0, 0, "R9");
        // R3: edge captured while C is masked
        cyc(1, 0, 8'h00, 0, 0, 1, 0, "R3");
        cyc(1, 0, 8'h00, 0, 0, 1, 0, "R3");
        cyc(1, 0, 8'h00, 0, 0, 1, 0, "R3");
        cyc(1, 0, 8'h00, 0, 0, 1, 0, "R3");
        // R5: acknowledge ignored while masked
        cyc(1, 0, 8'h00, 0, 0, 1, 1, "R5");
        cyc(1, 0, 8'h00, 0, 0, 1, 0, "R5");
        // R4: clear by write
        cyc(1, 1, 8'h10, 0, 0, 1, 0, "R4");
        // unmask all, new edge, then acknowledge clears
        cyc(1, 1, 8'h08, 0, 0, 0, 0, "R1");
        cyc(1, 0, 8'h00, 0, 0, 0, 0, "R3");
        cyc(1, 0, 8'h00, 0, 0, 0, 0, "R3");
        cyc(1, 0, 8'h00, 0, 0, 1, 0, "R3");
        cyc(1, 0, 8'h00, 0, 0, 1, 0, "R3");
        cyc(1, 0, 8'h00, 0, 0, 1, 0, "R3");
        cyc(1, 0, 8'h00, 0, 0, 1, 1, "R5");
        // R6: edge and write clear in the same cycle
        cyc(1, 0, 8'h00, 0, 0, 0, 0, "R6");
        cyc(1, 0, 8'h00, 0, 0, 0, 0, "R6");
        cyc(1, 0, 8'h00, 0, 0, 1, 0, "R6");
        cyc(1, 0, 8'h00, 0, 0, 1, 0, "R6");
        cyc(1, 1, 8'h10, 0, 0, 1, 1, "R6");
        // R7: serial latch load, hold, load zero
        cyc(1, 1, 8'hC0, 0, 0, 1, 0, "R7");
        cyc(1, 1, 8'h80, 0, 0, 1, 0, "R7");
        cyc(1, 1, 8'h40, 0, 0, 1, 0, "R7");
        cyc(1, 1, 8'hC0, 0, 0, 1, 0, "R7");
        // R10: reset with pin high, then edge seen after release
        cyc(0, 0, 8'h00, 0, 0, 1, 0, "R10");
        cyc(1, 0, 8'h00, 0, 0, 1, 0, "R10");
        cyc(1, 0, 8'h00, 0, 0, 1, 0, "R10");
        cyc(1, 0, 8'h00, 0, 0, 1, 0, "R10");
        // Random phase
        for (int i = 0; i < 3000; i++) begin
            logic       we, a, b, ack;
            logic [7:0] wd;
            logic       pin;
            we  = ($urandom % 100) < 30;
            wd  = 8'($urandom);
            a   = 1'($urandom);
            b   = 1'($urandom);
            ack = ($urandom % 100) < 20;
            pin = (($urandom % 100) < 25) ? ~irq_c_pin : irq_c_pin;
            cyc(($urandom % 500) != 0, we, wd, a, b, pin, ack, "R9");
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule